// File: doc/BRIEF.md
# Three-and-a-half digit static LCD drive generator

This block turns a latched reading into drive levels for a static liquid crystal display. The reading has three BCD digits, a half digit that can only show "1", a sign bit, an overrange flag and a lamp-test request. The block makes a backplane square wave by dividing the master clock. Each segment line runs at the same frequency as the backplane. A lit segment is driven in antiphase with the backplane and a dark segment in phase with it, so the average voltage across every segment stays at zero.

Two modes take priority over the plain digits. The overload mode blanks the three low digits and keeps the half digit and the sign. The lamp-test mode lights every segment, so the display reads -1888. In lamp test the backplane is held low and every segment is held high, which puts a steady DC level across the glass. Level shifting to the panel voltage and the decimal points are handled outside this block.

Top module: `lcd35_driver`

## Requirements
- R1: After reset `bp` is low. While `lamp` is low, `bp` changes level every DIV_HALF clock cycles (default 400), giving a period of 2*DIV_HALF cycles, which is the clock divided by 800. The first rise comes DIV_HALF cycles after reset is released.
- R2: Outside lamp test, every segment output equals `bp` when the segment is dark and equals the inverse of `bp` when it is lit. Segment lines and `bp` change on the same clock edge.
- R3: Each seven-segment field uses bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f, 6 = g. BCD values 0 to 9 light the standard patterns (hex, lit = 1): 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R4: Digit codes 10 to 15 light no segment in that digit.
- R5: `seg_thou` bit 0 is segment b and bit 1 is segment c of the half digit. Both are lit when `thou_one` is 1 and both are dark when it is 0.
- R6: `seg_minus` is lit when `neg` is 1 and dark when `neg` is 0.
- R7: When `ovr` is 1 and `lamp` is 0, the hundreds, tens and ones digits are dark for any input code. Both half-digit segments are lit, and the minus sign still follows `neg`.
- R8: When `lamp` is 1, all 24 segment lines are held high and `bp` is held low (the display reads -1888), no matter what `ovr`, `neg` or the digit inputs are.
- R9: Outputs are registered. A change on any data or mode input shows at the outputs after the next rising clock edge.
- R10: While `rst` is high, `bp` and every segment line are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_hund | input | 4 | Hundreds digit code |
| bcd_tens | input | 4 | Tens digit code |
| bcd_ones | input | 4 | Ones digit code |
| thou_one | input | 1 | Half digit shows "1" |
| neg | input | 1 | Reading is negative |
| ovr | input | 1 | Overrange: blank the low digits |
| lamp | input | 1 | Lamp test request |
| bp | output | 1 | Backplane square wave |
| seg_hund | output | 7 | Hundreds segments a..g |
| seg_tens | output | 7 | Tens segments a..g |
| seg_ones | output | 7 | Ones segments a..g |
| seg_thou | output | 2 | Half digit segments b, c |
| seg_minus | output | 1 | Minus sign segment |

## Verification
Each input change is applied just after a falling edge and shows at the outputs after exactly one rising edge. The bench therefore checks segment values at the next falling edge and compares each line with the expected lit pattern XOR the `bp` level sampled in the same half cycle. Backplane timing is checked by counting falling edges from reset release until the first rise, which is due after DIV_HALF edges, and then until the next fall, which is due after DIV_HALF more. Lamp test is sampled twice, more than one half period apart, to show that the levels do not change.

// File: rtl/lcd35_pkg.sv
package lcd35_pkg;

  typedef logic [6:0] seg7_t;

  localparam int NUM_FULL = 3;
  localparam int SEG_BITS = 7 * NUM_FULL + 3;

  // bit0=a ... bit6=g, lit = 1
  function automatic seg7_t bcd_to_seg7(input logic [3:0] code);
    seg7_t s;
    case (code)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;  // non-BCD shows nothing
    endcase
    return s;
  endfunction

  // level a segment line takes for a given backplane level
  function automatic logic drive_level(input logic lit, input logic bp_lvl);
    return lit ? ~bp_lvl : bp_lvl;
  endfunction

endpackage

// File: rtl/lcd35_bp_gen.sv
module lcd35_bp_gen #(
  parameter int DIV_HALF = 400
) (
  input  logic clk,
  input  logic rst,
  output logic phase,
  output logic phase_nxt
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = (cnt == LAST);
  assign phase_nxt = phase ^ wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else begin
      cnt   <= wrap ? '0 : cnt + 1'b1;
      phase <= phase_nxt;
    end
  end
endmodule

// File: rtl/lcd35_glyph.sv
module lcd35_glyph
  import lcd35_pkg::*;
(
  input  logic [3:0]          bcd_hund,
  input  logic [3:0]          bcd_tens,
  input  logic [3:0]          bcd_ones,
  input  logic                thou_one,
  input  logic                neg,
  input  logic                ovr,
  input  logic                lamp,
  output logic [SEG_BITS-1:0] on_pat
);
  logic [3:0] codes [NUM_FULL];
  seg7_t      full  [NUM_FULL];
  logic [1:0] thou_on;
  logic       minus_on;

  assign codes[0] = bcd_ones;
  assign codes[1] = bcd_tens;
  assign codes[2] = bcd_hund;

  for (genvar d = 0; d < NUM_FULL; d++) begin : g_digit
    always_comb begin
      if (lamp)     full[d] = 7'h7F;
      else if (ovr) full[d] = 7'h00;
      else          full[d] = bcd_to_seg7(codes[d]);
    end
    assign on_pat[7*d +: 7] = full[d];
  end

  assign thou_on  = (lamp || ovr || thou_one) ? 2'b11 : 2'b00;
  assign minus_on = lamp || neg;

  assign on_pat[7*NUM_FULL +: 2] = thou_on;
  assign on_pat[SEG_BITS-1]      = minus_on;
endmodule

// File: rtl/lcd35_phase_drv.sv
module lcd35_phase_drv
  import lcd35_pkg::*;
#(
  parameter int N = SEG_BITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lamp,
  input  logic         phase_nxt,
  input  logic [N-1:0] on_pat,
  output logic         bp,
  output logic [N-1:0] seg
);
  logic         bp_d;
  logic [N-1:0] seg_d;

  assign bp_d = lamp ? 1'b0 : phase_nxt;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign seg_d[i] = lamp ? 1'b1 : drive_level(on_pat[i], phase_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp  <= 1'b0;
      seg <= '0;
    end else begin
      bp  <= bp_d;
      seg <= seg_d;
    end
  end
endmodule

// File: rtl/lcd35_driver.sv
module lcd35_driver
  import lcd35_pkg::*;
#(
  parameter int DIV_HALF = 400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] bcd_hund,
  input  logic [3:0] bcd_tens,
  input  logic [3:0] bcd_ones,
  input  logic       thou_one,
  input  logic       neg,
  input  logic       ovr,
  input  logic       lamp,
  output logic       bp,
  output logic [6:0] seg_hund,
  output logic [6:0] seg_tens,
  output logic [6:0] seg_ones,
  output logic [1:0] seg_thou,
  output logic       seg_minus
);
  logic                phase;
  logic                phase_nxt;
  logic [SEG_BITS-1:0] on_pat;
  logic [SEG_BITS-1:0] seg_all;

  lcd35_bp_gen #(.DIV_HALF(DIV_HALF)) bp_gen_i (
    .clk(clk), .rst(rst), .phase(phase), .phase_nxt(phase_nxt)
  );

  lcd35_glyph glyph_i (
    .bcd_hund(bcd_hund), .bcd_tens(bcd_tens), .bcd_ones(bcd_ones),
    .thou_one(thou_one), .neg(neg), .ovr(ovr), .lamp(lamp),
    .on_pat(on_pat)
  );

  lcd35_phase_drv #(.N(SEG_BITS)) drv_i (
    .clk(clk), .rst(rst), .lamp(lamp), .phase_nxt(phase_nxt),
    .on_pat(on_pat), .bp(bp), .seg(seg_all)
  );

  assign seg_ones  = seg_all[6:0];
  assign seg_tens  = seg_all[13:7];
  assign seg_hund  = seg_all[20:14];
  assign seg_thou  = seg_all[22:21];
  assign seg_minus = seg_all[23];
endmodule

// File: rtl/lcd35_driver_chk.sv
module lcd35_driver_chk #(
  parameter int DIV_HALF = 400
) (
  input logic        clk,
  input logic        rst,
  input logic        phase,
  input logic [23:0] on_pat,
  input logic [23:0] seg_all,
  input logic        bp,
  input logic        lamp,
  input logic        ovr,
  input logic        neg
);
  localparam int KW = $clog2(DIV_HALF + 1) + 1;

  logic          phase_d;
  logic [KW-1:0] since;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_d <= 1'b0;
      since   <= '0;
    end else begin
      phase_d <= phase;
      since   <= (phase != phase_d) ? KW'(1) : since + 1'b1;
    end
  end

  assert_half_period_R1: assert property (@(posedge clk) disable iff (rst)
    (phase != phase_d) |-> (since == KW'(DIV_HALF)));

  assert_no_long_half_R1: assert property (@(posedge clk) disable iff (rst)
    since <= KW'(DIV_HALF));

  assert_antiphase_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(lamp) && !$past(rst) |-> (seg_all == ($past(on_pat) ^ {24{bp}})));

  assert_blank_low_R7: assert property (@(posedge clk) disable iff (rst)
    $past(ovr) && !$past(lamp) && !$past(rst) |-> (seg_all[20:0] == {21{bp}}));

  assert_minus_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(lamp) && !$past(rst) |-> (seg_all[23] == ($past(neg) ^ bp)));

  assert_lamp_dc_R8: assert property (@(posedge clk) disable iff (rst)
    $past(lamp) && !$past(rst) |-> (seg_all == '1 && !bp));
endmodule

bind lcd35_driver lcd35_driver_chk #(.DIV_HALF(DIV_HALF)) chk_i (
  .clk(clk), .rst(rst), .phase(phase), .on_pat(on_pat), .seg_all(seg_all),
  .bp(bp), .lamp(lamp), .ovr(ovr), .neg(neg)
);

// File: tb/lcd35_driver_tb.sv
module lcd35_driver_tb_top;
  localparam int HALF = 400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bcd_hund = '0, bcd_tens = '0, bcd_ones = '0;
  logic       thou_one = 1'b0, neg = 1'b0, ovr = 1'b0, lamp = 1'b0;
  logic       bp;
  logic [6:0] seg_hund, seg_tens, seg_ones;
  logic [1:0] seg_thou;
  logic       seg_minus;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lcd35_driver #(.DIV_HALF(HALF)) dut_i (
    .clk(clk), .rst(rst), .bcd_hund(bcd_hund), .bcd_tens(bcd_tens),
    .bcd_ones(bcd_ones), .thou_one(thou_one), .neg(neg), .ovr(ovr),
    .lamp(lamp), .bp(bp), .seg_hund(seg_hund), .seg_tens(seg_tens),
    .seg_ones(seg_ones), .seg_thou(seg_thou), .seg_minus(seg_minus)
  );

  // lit patterns from R3, index = digit value, bit0 = a
  localparam logic [6:0] GLYPH [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                        7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};

  function automatic logic [6:0] lit_of(input logic [3:0] v);
    return (v < 4'd10) ? GLYPH[v] : 7'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply at negedge, result due after one rising edge
  task automatic apply(input logic [3:0] h, input logic [3:0] t, input logic [3:0] o,
                       input logic th, input logic n, input logic ov, input logic lt);
    bcd_hund = h; bcd_tens = t; bcd_ones = o;
    thou_one = th; neg = n; ovr = ov; lamp = lt;
    @(posedge clk); @(negedge clk);
  endtask

  // compare every line against lit pattern XOR sampled backplane
  task automatic expect_lit(input string req, input logic [6:0] h, input logic [6:0] t,
                            input logic [6:0] o, input logic [1:0] th, input logic m);
    chk({req, " hund"},  32'(seg_hund),  32'(h  ^ {7{bp}}));
    chk({req, " tens"},  32'(seg_tens),  32'(t  ^ {7{bp}}));
    chk({req, " ones"},  32'(seg_ones),  32'(o  ^ {7{bp}}));
    chk({req, " thou"},  32'(seg_thou),  32'(th ^ {2{bp}}));
    chk({req, " minus"}, 32'(seg_minus), 32'(m  ^ bp));
  endtask

  task automatic t_reset_R10();
    chk("R10 bp", 32'(bp), 32'd0);
    chk("R10 segs", 32'({seg_minus, seg_thou, seg_hund, seg_tens, seg_ones}), 32'd0);
  endtask

  task automatic t_backplane_R1();
    int n = 0;
    rst = 1'b0;
    while (bp !== 1'b1 && n < 3 * HALF) begin
      @(posedge clk); @(negedge clk); n++;
    end
    chk("R1 first rise cycles", 32'(n), 32'(HALF));
    n = 0;
    while (bp !== 1'b0 && n < 3 * HALF) begin
      @(posedge clk); @(negedge clk); n++;
    end
    chk("R1 half period cycles", 32'(n), 32'(HALF));
  endtask

  task automatic t_digits_R3();
    for (int v = 0; v < 10; v++) begin
      apply(4'(v), 4'((v + 3) % 10), 4'((v + 7) % 10), 1'b0, 1'b0, 1'b0, 1'b0);
      expect_lit("R3", lit_of(4'(v)), lit_of(4'((v + 3) % 10)),
                 lit_of(4'((v + 7) % 10)), 2'b00, 1'b0);
    end
  endtask

  task automatic t_phase_R2();
    // show one reading in both backplane levels
    apply(4'd1, 4'd2, 4'd8, 1'b1, 1'b0, 1'b0, 1'b0);
    while (bp !== 1'b1) begin @(posedge clk); @(negedge clk); end
    expect_lit("R2 bp high", 7'h06, 7'h5B, 7'h7F, 2'b11, 1'b0);
    while (bp !== 1'b0) begin @(posedge clk); @(negedge clk); end
    expect_lit("R2 bp low", 7'h06, 7'h5B, 7'h7F, 2'b11, 1'b0);
  endtask

  task automatic t_nonbcd_R4();
    for (int v = 10; v < 16; v++) begin
      apply(4'(v), 4'(v), 4'(v), 1'b0, 1'b0, 1'b0, 1'b0);
      expect_lit("R4", 7'h00, 7'h00, 7'h00, 2'b00, 1'b0);
    end
  endtask

  task automatic t_half_sign_R5_R6();
    apply(4'd9, 4'd9, 4'd9, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_lit("R5 half on", 7'h6F, 7'h6F, 7'h6F, 2'b11, 1'b0);
    apply(4'd9, 4'd9, 4'd9, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_lit("R6 minus on", 7'h6F, 7'h6F, 7'h6F, 2'b00, 1'b1);
  endtask

  task automatic t_overload_R7();
    apply(4'd8, 4'd8, 4'd8, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_lit("R7 ovr pos", 7'h00, 7'h00, 7'h00, 2'b11, 1'b0);
    apply(4'd5, 4'd0, 4'd3, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_lit("R7 ovr neg", 7'h00, 7'h00, 7'h00, 2'b11, 1'b1);
  endtask

  task automatic t_lamp_R8();
    apply(4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 segs", 32'({seg_minus, seg_thou, seg_hund, seg_tens, seg_ones}), 32'hFF_FFFF);
    chk("R8 bp", 32'(bp), 32'd0);
    repeat (HALF + 50) begin @(posedge clk); @(negedge clk); end
    chk("R8 segs later", 32'({seg_minus, seg_thou, seg_hund, seg_tens, seg_ones}), 32'hFF_FFFF);
    chk("R8 bp later", 32'(bp), 32'd0);
  endtask

  task automatic t_latency_R9();
    apply(4'd3, 4'd4, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    bcd_ones = 4'd6;  // change after negedge: not yet visible
    #1;
    chk("R9 before edge", 32'(seg_ones), 32'(7'h6D ^ {7{bp}}));
    @(posedge clk); @(negedge clk);
    chk("R9 after edge", 32'(seg_ones), 32'(7'h7D ^ {7{bp}}));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_R10();
    t_backplane_R1();
    t_digits_R3();
    t_phase_R2();
    t_nonbcd_R4();
    t_half_sign_R5_R6();
    t_overload_R7();
    t_lamp_R8();
    t_latency_R9();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule